// File: doc/BRIEF.md
# Breakpoint Acknowledge Bus Sequencer

This block is the bus-master side of a special read cycle on a synchronous 32-bit processor bus. The processor runs this cycle to acknowledge a breakpoint. When a request arrives, the sequencer starts the cycle. It drives a fixed all-zero address and a fixed set of attribute codes that mark the cycle as special. It pulses a transfer-start strobe for one clock and keeps a transfer-busy indication up until the cycle ends.

A status strobe goes with the cycle. It may rise at once, or it may be held back by a programmable ignore count. A retry ending sends the sequencer back to the start of the cycle. A normal or bus-error ending closes the cycle and raises a one-clock exception request that carries vector number 4. A downstream exception engine consumes that request. The system side supplies the termination inputs.

Top module: `bkpt_ack_seq`

## Requirements
- R1: After reset, and while no cycle is running, xfer_start, xfer_busy, stat_strobe and exc_req are 0 and exc_vector is 0.
- R2: bkpt_req is sampled high in idle at a clock edge. After that edge, xfer_start is 1 for exactly one clock. xfer_busy is 1 from that clock until the clock in which the cycle ends.
- R3: While xfer_busy is 1, the outputs take these values: bus_addr = 0, bus_rd = 1 (read), page_attr = 0, xfer_type = 3, xfer_mod = 0, line_num = 0, xfer_size = 2'b01 (one byte), byte_sel = 4'b0001 (lane 0 only), and cache_inh = bus_lock = lock_end = 0.
- R4: If ign_en is 0 when the cycle starts, stat_strobe is 1 in the xfer_start clock and in every later clock of the cycle.
- R5: If ign_en is 1 and ign_cnt = N when the cycle starts, stat_strobe is 0 in the xfer_start clock and in the N clocks that follow it. It is 1 from clock N+1 after xfer_start until the cycle ends.
- R6: term_ack or term_err may be sampled at an edge after the xfer_start clock. In the next clock, xfer_busy and stat_strobe are 0 and exc_req is 1 for one clock. While exc_req is 1, exc_vector = 4. While exc_req is 0, exc_vector = 0.
- R7: term_retry may be sampled at an edge after the xfer_start clock. In the next clock, xfer_start is 1 again and exc_req stays 0. The ignore setting and count are taken afresh at that restart.
- R8: When several termination inputs are high together, retry wins over bus error, and bus error wins over normal acknowledge.
- R9: Termination inputs sampled in the xfer_start clock are ignored: the cycle stays busy and no exception is raised.
- R10: If bkpt_req is still high in the clock in which exc_req is 1, a new xfer_start follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bkpt_req | input | 1 | Request to run an acknowledge cycle |
| ign_en | input | 1 | Enables the status strobe delay |
| ign_cnt | input | CNT_W | Strobe delay in clocks |
| term_ack | input | 1 | Normal termination |
| term_err | input | 1 | Bus-error termination |
| term_retry | input | 1 | Retry termination |
| bus_addr | output | ADDR_W | Address bus |
| bus_rd | output | 1 | 1 = read |
| page_attr | output | 2 | User page attribute bits |
| xfer_type | output | 2 | Transfer type code |
| xfer_mod | output | 3 | Transfer modifier code |
| line_num | output | 2 | Transfer line number |
| xfer_size | output | 2 | Transfer size code |
| byte_sel | output | 4 | Byte lane selects, active high |
| cache_inh | output | 1 | Cache-inhibit out |
| bus_lock | output | 1 | Locked transfer |
| lock_end | output | 1 | Last locked transfer |
| xfer_start | output | 1 | Transfer start, one clock |
| xfer_busy | output | 1 | Transfer in progress |
| stat_strobe | output | 1 | Status strobe |
| exc_req | output | 1 | Exception request pulse |
| exc_vector | output | VEC_W | Exception vector number |

## Verification
The bench builds the block with its default parameters: a 4-bit ignore count, an 8-bit vector and vector value 4. With these values the bench can reach both ends of the delay range. It runs a zero count, a middle count and the maximum count of 15. In each run it watches the exact clock in which the strobe rises. It also reloads the count on a retry, forces all three terminations into conflict, and sends terminations during the start clock and back-to-back requests.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_state_t;
  typedef enum logic [1:0] {TM_NONE, TM_ACK, TM_ERR, TM_RETRY} term_t;

  function automatic term_t term_pick(input logic ack, input logic err, input logic rty);
    if (rty)      return TM_RETRY;
    else if (err) return TM_ERR;
    else if (ack) return TM_ACK;
    return TM_NONE;
  endfunction

  function automatic logic term_closes(input term_t k);
    return (k == TM_ACK) || (k == TM_ERR);
  endfunction
endpackage

// File: rtl/bkpt_term_arb.sv
module bkpt_term_arb
  import bkpt_pkg::*;
(
  input  logic  accept,
  input  logic  term_ack,
  input  logic  term_err,
  input  logic  term_retry,
  output term_t kind
);
  always_comb begin
    kind = TM_NONE;
    if (accept) kind = term_pick(term_ack, term_err, term_retry);
  end
endmodule

// File: rtl/bkpt_ign_cnt.sv
module bkpt_ign_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             gate_on,
  output logic             en_seen
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      en_q  <= load_en;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign gate_on = !en_q || (cnt_q == '0);
  assign en_seen = en_q;
endmodule

// File: rtl/bkpt_attr_drive.sv
module bkpt_attr_drive #(
  parameter int ADDR_W  = 32,
  parameter int TT_CODE = 3
) (
  input  logic              active,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic [1:0]        page_attr,
  output logic [1:0]        xfer_type,
  output logic [2:0]        xfer_mod,
  output logic [1:0]        line_num,
  output logic [1:0]        xfer_size,
  output logic [3:0]        byte_sel,
  output logic              cache_inh,
  output logic              bus_lock,
  output logic              lock_end
);
  localparam logic [1:0] SIZE_BYTE = 2'b01;

  assign bus_addr  = '0;
  assign bus_rd    = 1'b1;
  assign page_attr = 2'b00;
  assign xfer_type = active ? 2'(TT_CODE) : 2'b00;
  assign xfer_mod  = 3'b000;
  assign line_num  = 2'b00;
  assign xfer_size = active ? SIZE_BYTE : 2'b00;
  assign byte_sel  = active ? 4'b0001 : 4'b0000;
  assign cache_inh = 1'b0;
  assign bus_lock  = 1'b0;
  assign lock_end  = 1'b0;
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
  import bkpt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 4,
  parameter int VEC_W   = 8,
  parameter int EXC_VEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkpt_req,
  input  logic              ign_en,
  input  logic [CNT_W-1:0]  ign_cnt,
  input  logic              term_ack,
  input  logic              term_err,
  input  logic              term_retry,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic [1:0]        page_attr,
  output logic [1:0]        xfer_type,
  output logic [2:0]        xfer_mod,
  output logic [1:0]        line_num,
  output logic [1:0]        xfer_size,
  output logic [3:0]        byte_sel,
  output logic              cache_inh,
  output logic              bus_lock,
  output logic              lock_end,
  output logic              xfer_start,
  output logic              xfer_busy,
  output logic              stat_strobe,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vector
);
  seq_state_t st_q, st_nxt;
  term_t      term_kind;
  logic       start_load;
  logic       cycle_close;
  logic       gate_on;
  logic       en_seen;
  logic       exc_q;

  bkpt_term_arb u_arb (
    .accept     (st_q == ST_WAIT),
    .term_ack   (term_ack),
    .term_err   (term_err),
    .term_retry (term_retry),
    .kind       (term_kind)
  );

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE:  if (bkpt_req) st_nxt = ST_START;
      ST_START: st_nxt = ST_WAIT;
      ST_WAIT: begin
        if (term_kind == TM_RETRY)  st_nxt = ST_START;
        else if (term_closes(term_kind)) st_nxt = ST_IDLE;
      end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  assign start_load  = (st_nxt == ST_START) && (st_q != ST_START);
  assign cycle_close = term_closes(term_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      exc_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      exc_q <= cycle_close;
    end
  end

  bkpt_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_load),
    .load_en  (ign_en),
    .load_val (ign_cnt),
    .run      (st_q == ST_WAIT),
    .gate_on  (gate_on),
    .en_seen  (en_seen)
  );

  bkpt_attr_drive #(.ADDR_W(ADDR_W), .TT_CODE(3)) u_attr (
    .active    (xfer_busy),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .page_attr (page_attr),
    .xfer_type (xfer_type),
    .xfer_mod  (xfer_mod),
    .line_num  (line_num),
    .xfer_size (xfer_size),
    .byte_sel  (byte_sel),
    .cache_inh (cache_inh),
    .bus_lock  (bus_lock),
    .lock_end  (lock_end)
  );

  assign xfer_start  = (st_q == ST_START);
  assign xfer_busy   = (st_q != ST_IDLE);
  assign stat_strobe = (xfer_start && !en_seen) || ((st_q == ST_WAIT) && gate_on);
  assign exc_req     = exc_q;
  assign exc_vector  = exc_q ? VEC_W'(EXC_VEC) : '0;
endmodule

// File: rtl/bkpt_ack_seq_chk.sv
module bkpt_ack_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int VEC_W   = 8,
  parameter int EXC_VEC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ign_en,
  input logic              term_ack,
  input logic              term_err,
  input logic              term_retry,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        byte_sel,
  input logic [1:0]        xfer_type,
  input logic              xfer_start,
  input logic              xfer_busy,
  input logic              stat_strobe,
  input logic              exc_req,
  input logic [VEC_W-1:0]  exc_vector
);
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> xfer_busy);
  p_attr_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (bus_addr == '0 && byte_sel == 4'b0001 && xfer_type == 2'd3));
  p_strobe_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !$past(ign_en)) |-> stat_strobe);
  p_strobe_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strobe |-> xfer_busy);
  p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !xfer_start && !term_retry && (term_ack || term_err))
      |=> (!xfer_busy && exc_req));
  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_vector == VEC_W'(EXC_VEC));
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !xfer_start && term_retry) |=> (xfer_start && !exc_req));
  p_start_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (xfer_busy && !exc_req));
endmodule

bind bkpt_ack_seq bkpt_ack_seq_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .EXC_VEC(EXC_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ign_en      (ign_en),
  .term_ack    (term_ack),
  .term_err    (term_err),
  .term_retry  (term_retry),
  .bus_addr    (bus_addr),
  .byte_sel    (byte_sel),
  .xfer_type   (xfer_type),
  .xfer_start  (xfer_start),
  .xfer_busy   (xfer_busy),
  .stat_strobe (stat_strobe),
  .exc_req     (exc_req),
  .exc_vector  (exc_vector)
);

// File: tb/bkpt_ack_seq_test.sv
module bkpt_ack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkpt_req = 1'b0, ign_en = 1'b0;
  logic [3:0]  ign_cnt = 4'd0;
  logic        term_ack = 1'b0, term_err = 1'b0, term_retry = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_rd, cache_inh, bus_lock, lock_end;
  logic [1:0]  page_attr, xfer_type, line_num, xfer_size;
  logic [2:0]  xfer_mod;
  logic [3:0]  byte_sel;
  logic        xfer_start, xfer_busy, stat_strobe, exc_req;
  logic [7:0]  exc_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bkpt_ack_seq uut (
    .clk(clk), .rst_n(rst_n), .bkpt_req(bkpt_req), .ign_en(ign_en), .ign_cnt(ign_cnt),
    .term_ack(term_ack), .term_err(term_err), .term_retry(term_retry),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .page_attr(page_attr), .xfer_type(xfer_type),
    .xfer_mod(xfer_mod), .line_num(line_num), .xfer_size(xfer_size), .byte_sel(byte_sel),
    .cache_inh(cache_inh), .bus_lock(bus_lock), .lock_end(lock_end),
    .xfer_start(xfer_start), .xfer_busy(xfer_busy), .stat_strobe(stat_strobe),
    .exc_req(exc_req), .exc_vector(exc_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_idle(input string tag);
    chk(xfer_start == 0 && xfer_busy == 0 && stat_strobe == 0, tag,
        {xfer_start, xfer_busy, stat_strobe}, 0);
    chk(exc_req == 0 && exc_vector == 0, tag, {exc_req, exc_vector}, 0);
  endtask

  task automatic chk_attr();
    chk(bus_addr == 0 && bus_rd == 1 && page_attr == 0 && xfer_type == 3 && xfer_mod == 0 &&
        line_num == 0 && xfer_size == 2'b01 && byte_sel == 4'b0001 &&
        cache_inh == 0 && bus_lock == 0 && lock_end == 0, "R3 attributes",
        {bus_rd, page_attr, xfer_type, xfer_mod, line_num, xfer_size, byte_sel,
         cache_inh, bus_lock, lock_end}, 0);
  endtask

  // the clock after a request edge: start clock
  task automatic begin_cycle(input bit en, input logic [3:0] n);
    ign_en = en; ign_cnt = n; bkpt_req = 1'b1;
    tick();
    bkpt_req = 1'b0;
    chk(xfer_start == 1 && xfer_busy == 1, "R2 start clock", {xfer_start, xfer_busy}, 2'b11);
    chk_attr();
    chk(stat_strobe == !en, en ? "R5 strobe off at start" : "R4 strobe at start",
        stat_strobe, !en);
  endtask

  // wait clocks 1..waits, ending the cycle in clock 'waits' with err or ack
  task automatic wait_and_close(input bit en, input int n, input int waits, input bit use_err);
    for (int k = 1; k <= waits; k++) begin
      tick();
      chk(xfer_start == 0 && xfer_busy == 1, "R2 single start, busy held",
          {xfer_start, xfer_busy}, 2'b01);
      chk(stat_strobe == (!en || k >= n + 1), en ? "R5 delayed strobe" : "R4 strobe held",
          stat_strobe, (!en || k >= n + 1));
      if (k == waits) begin
        if (use_err) term_err = 1'b1; else term_ack = 1'b1;
      end
    end
    tick();
    term_err = 1'b0; term_ack = 1'b0;
    chk(xfer_busy == 0 && stat_strobe == 0 && exc_req == 1, "R6 close",
        {xfer_busy, stat_strobe, exc_req}, 3'b001);
    chk(exc_vector == 8'd4, "R6 vector", exc_vector, 4);
    tick();
    chk_idle("R6 exception one clock / R1 idle");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk_idle("R1 reset");
    rst_n = 1'b1;
    tick();
    chk_idle("R1 idle after reset");
  endtask

  task automatic t_no_delay();
    begin_cycle(1'b0, 4'd9);
    wait_and_close(1'b0, 9, 3, 1'b0);
  endtask

  task automatic t_delay(input logic [3:0] n, input bit use_err);
    begin_cycle(1'b1, n);
    wait_and_close(1'b1, int'(n), int'(n) + 2, use_err);
  endtask

  task automatic t_retry();
    begin_cycle(1'b1, 4'd5);
    tick();
    term_retry = 1'b1; ign_cnt = 4'd2;
    tick();
    term_retry = 1'b0;
    chk(xfer_start == 1 && exc_req == 0, "R7 restart", {xfer_start, exc_req}, 2'b10);
    chk(stat_strobe == 0, "R7 strobe off at restart", stat_strobe, 0);
    wait_and_close(1'b1, 2, 4, 1'b0);
  endtask

  task automatic t_priority();
    begin_cycle(1'b0, 4'd0);
    tick();
    term_retry = 1'b1; term_err = 1'b1; term_ack = 1'b1;
    tick();
    term_retry = 1'b0; term_err = 1'b0; term_ack = 1'b0;
    chk(xfer_start == 1 && exc_req == 0, "R8 retry wins", {xfer_start, exc_req}, 2'b10);
    tick();
    term_err = 1'b1; term_ack = 1'b1;
    tick();
    term_err = 1'b0; term_ack = 1'b0;
    chk(exc_req == 1 && xfer_busy == 0 && exc_vector == 4, "R8 error/ack closes",
        {exc_req, xfer_busy, exc_vector}, {2'b10, 8'd4});
    tick();
    chk_idle("R8 back to idle");
  endtask

  task automatic t_start_ignores();
    begin_cycle(1'b0, 4'd0);
    term_ack = 1'b1; term_retry = 1'b1;
    tick();
    term_ack = 1'b0; term_retry = 1'b0;
    chk(xfer_busy == 1 && xfer_start == 0 && exc_req == 0, "R9 terms in start clock ignored",
        {xfer_busy, xfer_start, exc_req}, 3'b100);
    wait_and_close(1'b0, 0, 2, 1'b1);
  endtask

  task automatic t_back_to_back();
    begin_cycle(1'b0, 4'd0);
    bkpt_req = 1'b1;
    tick();
    term_ack = 1'b1;
    tick();
    term_ack = 1'b0;
    chk(exc_req == 1 && xfer_busy == 0, "R10 exception clock", {exc_req, xfer_busy}, 2'b10);
    tick();
    bkpt_req = 1'b0;
    chk(xfer_start == 1 && exc_req == 0, "R10 next start", {xfer_start, exc_req}, 2'b10);
    wait_and_close(1'b0, 0, 1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_delay();
    t_delay(4'd0, 1'b0);
    t_delay(4'd6, 1'b1);
    t_delay(4'd15, 1'b0);
    t_retry();
    t_priority();
    t_start_ignores();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule